// File: doc/BRIEF.md
# Receive Frame Queue with Status Header

This block sits between a MAC receive interface and a host that reads received frames through one 16-bit data port. Bytes arriving from the MAC are written into a ring of fixed-size frame slots. When the last byte of a frame arrives, the block records a per-frame header in the same slot. The header holds four error flags, the byte count and two statistics bytes that the MAC supplies with the last byte.

The host polls a frame-count output, or waits on an interrupt line, to learn that frames are waiting. For the frame at the head of the queue, successive read strobes return the status word, then the runt-count byte, then the collision-count byte, then the payload packed two bytes per word. A release strobe drops the head frame at any point in that sequence, and the next read starts on the following frame. If the queue is already full when a frame begins, the whole frame is discarded and a missed-frame counter steps.

Top module: `rx_frame_queue`

## Requirements
- R1: Up to DEPTH (12) complete frames are held. `frame_count` gives the number of complete frames waiting and never exceeds DEPTH. It rises in the cycle after the clock edge that accepts a frame's last byte.
- R2: A frame whose first byte arrives while DEPTH frames are stored is discarded in full. `frame_count` stays unchanged, and `missed_cnt` (8 bits, wrapping) increments once, in the cycle after the frame's last byte.
- R3: The first read of the head frame returns the status word. Bit 15 is overflow, bit 14 is collision, bit 13 is framing error and bit 12 is FCS error. Bits 11:0 hold the number of bytes delivered for the frame, FCS included.
- R4: The second read returns the runt count and the third read returns the receive collision count. Each is the value on `mac_runt`/`mac_coll` with the frame's last byte, placed in bits 7:0 with bits 15:8 zero.
- R5: Each later read returns two payload bytes, the earlier byte in bits 7:0. For an odd length, the final read carries the last byte in bits 7:0.
- R6: A `host_next` pulse with frames waiting releases the head frame, however much of it was read. `frame_count` drops by one, and the next read returns the following frame's status word.
- R7: A `host_next` pulse with no frames waiting has no effect. A read with no frames waiting returns 16'h0000.
- R8: `rx_irq` is high in exactly the cycles in which `frame_count` is nonzero.
- R9: Bytes past SLOT_BYTES (64) in a frame are not stored, and bit 15 of the status word is forced to 1 for that frame. The length field still counts every byte delivered and saturates at 4095.
- R10: Frames are returned in arrival order, including when the slot ring wraps.
- R11: Read data appears on `host_data` in the cycle after the `host_rd` pulse and is held until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mac_valid | input | 1 | Receive byte valid |
| mac_byte | input | 8 | Receive byte |
| mac_last | input | 1 | Marks the final byte of a frame (with mac_valid) |
| mac_flags | input | 4 | Error flags sampled with the last byte: [3] overflow, [2] collision, [1] framing, [0] FCS |
| mac_runt | input | 8 | Runt count sampled with the last byte |
| mac_coll | input | 8 | Collision count sampled with the last byte |
| host_rd | input | 1 | Read strobe for the data port |
| host_next | input | 1 | Release strobe for the head frame |
| host_data | output | 16 | Data port |
| frame_count | output | 4 | Number of complete frames waiting |
| rx_irq | output | 1 | Frames-waiting interrupt |
| missed_cnt | output | 8 | Frames dropped because the queue was full |

## Verification
The main sweep sends frames of every length from 1 to 64 bytes, one at a time. The flags, statistics bytes and data seed all follow the length, so a read from the wrong word or the wrong bank, or a wrong odd-length tail, shows up at a specific length. Because the sweep runs past the slot count many times, it also covers ring wrap. A fill pattern queues twelve frames of different lengths, offers a thirteenth, and then drains the queue, alternating full reads with releases after the status word only. This separates correct ordering and drop counting from releases that skip the remainder. Separate frames of 70 and 4100 bytes cover truncation and length saturation. Operations on an empty queue come first.

// File: rtl/rfq_pkg.sv
package rfq_pkg;
  typedef enum logic [2:0] {
    PH_HDR,
    PH_RUNT,
    PH_COLL,
    PH_PAY,
    PH_NONE
  } rd_phase_e;
endpackage

// File: rtl/rfq_bank.sv
module rfq_bank #(
  parameter int WORDS = 384,
  parameter int AW    = 9
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);
  logic [7:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/rfq_ingest.sv
module rfq_ingest #(
  parameter int DEPTH      = 12,
  parameter int SLOT_BYTES = 64
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          in_valid,
  input  logic [7:0]                    in_byte,
  input  logic                          in_last,
  input  logic [3:0]                    in_flags,
  input  logic                          full,
  output logic                          wr_even,
  output logic                          wr_odd,
  output logic [$clog2(DEPTH)+$clog2(SLOT_BYTES)-2:0] wr_addr,
  output logic [7:0]                    wr_byte,
  output logic                          commit,
  output logic [$clog2(DEPTH)-1:0]      commit_slot,
  output logic [15:0]                   commit_status,
  output logic                          drop_done
);
  localparam int SW = $clog2(DEPTH);
  localparam int OW = $clog2(SLOT_BYTES);
  localparam logic [12:0] SLOT_LIM = 13'(SLOT_BYTES);

  logic [SW-1:0] slot_q;
  logic [11:0]   len_q;
  logic          in_frame_q, dropping_q, trunc_q;
  logic [11:0]   len_inc;
  logic          beyond, drop_now, keep, store;

  assign len_inc  = (len_q == 12'hFFF) ? len_q : len_q + 12'd1;
  assign beyond   = ({1'b0, len_q} >= SLOT_LIM);
  assign drop_now = in_frame_q ? dropping_q : full;
  assign keep     = in_valid & ~drop_now;
  assign store    = keep & ~beyond;

  assign wr_even       = store & ~len_q[0];
  assign wr_odd        = store & len_q[0];
  assign wr_addr       = {slot_q, len_q[OW-1:1]};
  assign wr_byte       = in_byte;
  assign commit        = keep & in_last;
  assign commit_slot   = slot_q;
  assign commit_status = {in_flags[3] | trunc_q | beyond, in_flags[2:0], len_inc};
  assign drop_done     = in_valid & in_last & drop_now;

  always_ff @(posedge clk) begin
    if (rst) begin
      slot_q     <= '0;
      len_q      <= '0;
      in_frame_q <= 1'b0;
      dropping_q <= 1'b0;
      trunc_q    <= 1'b0;
    end else if (in_valid) begin
      if (in_last) begin
        in_frame_q <= 1'b0;
        dropping_q <= 1'b0;
        trunc_q    <= 1'b0;
        len_q      <= '0;
        if (!drop_now)
          slot_q <= (slot_q == SW'(DEPTH-1)) ? '0 : slot_q + SW'(1);
      end else begin
        in_frame_q <= 1'b1;
        dropping_q <= drop_now;
        trunc_q    <= trunc_q | beyond;
        len_q      <= len_inc;
      end
    end
  end

  // R9: once a frame has passed the slot size, no further bytes of it are stored
  p_no_store_past_slot_r9: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !in_last && !drop_now && beyond) |=> !(wr_even || wr_odd) || !in_frame_q || !in_valid);
endmodule

// File: rtl/rfq_reader.sv
module rfq_reader
  import rfq_pkg::*;
#(
  parameter int DEPTH      = 12,
  parameter int SLOT_BYTES = 64
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          host_rd,
  input  logic                          host_next,
  input  logic                          count_nz,
  output logic [$clog2(DEPTH)-1:0]      head,
  output rd_phase_e                     cur_phase,
  output rd_phase_e                     sel,
  output logic                          rd_fire,
  output logic                          ram_re,
  output logic [$clog2(DEPTH)+$clog2(SLOT_BYTES)-2:0] ram_raddr,
  output logic                          release_head
);
  localparam int SW = $clog2(DEPTH);
  localparam int PW = $clog2(SLOT_BYTES) - 1;

  logic [PW-1:0] ptr_q;

  assign release_head = host_next & count_nz;
  assign rd_fire      = host_rd & ~host_next;
  assign ram_re       = rd_fire & count_nz & (cur_phase == PH_PAY);
  assign ram_raddr    = {head, ptr_q};

  always_ff @(posedge clk) begin
    if (rst) begin
      head      <= '0;
      ptr_q     <= '0;
      cur_phase <= PH_HDR;
      sel       <= PH_NONE;
    end else if (release_head) begin
      head      <= (head == SW'(DEPTH-1)) ? '0 : head + SW'(1);
      ptr_q     <= '0;
      cur_phase <= PH_HDR;
    end else if (rd_fire) begin
      if (!count_nz) begin
        sel <= PH_NONE;
      end else begin
        sel <= cur_phase;
        case (cur_phase)
          PH_HDR:  cur_phase <= PH_RUNT;
          PH_RUNT: cur_phase <= PH_COLL;
          PH_COLL: cur_phase <= PH_PAY;
          default: ptr_q     <= ptr_q + PW'(1);
        endcase
      end
    end
  end

  // R11: a read on a non-empty queue selects a real source for the next cycle
  p_read_selects_r11: assert property (@(posedge clk) disable iff (rst)
    (rd_fire && count_nz) |=> (sel != PH_NONE));
  // R6: a release restarts the sequence at the status word
  p_release_restarts_r6: assert property (@(posedge clk) disable iff (rst)
    release_head |=> (cur_phase == PH_HDR));
endmodule

// File: rtl/rx_frame_queue.sv
module rx_frame_queue
  import rfq_pkg::*;
#(
  parameter int DEPTH      = 12,
  parameter int SLOT_BYTES = 64
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        mac_valid,
  input  logic [7:0]  mac_byte,
  input  logic        mac_last,
  input  logic [3:0]  mac_flags,
  input  logic [7:0]  mac_runt,
  input  logic [7:0]  mac_coll,
  input  logic        host_rd,
  input  logic        host_next,
  output logic [15:0] host_data,
  output logic [3:0]  frame_count,
  output logic        rx_irq,
  output logic [7:0]  missed_cnt
);
  localparam int SW    = $clog2(DEPTH);
  localparam int AW    = SW + $clog2(SLOT_BYTES) - 1;
  localparam int WORDS = DEPTH * SLOT_BYTES / 2;

  logic          wr_even, wr_odd, commit, drop_done;
  logic [AW-1:0] wr_addr, ram_raddr;
  logic [7:0]    wr_byte;
  logic [SW-1:0] commit_slot, head;
  logic [15:0]   commit_status;
  logic          rd_fire, ram_re, release_head, count_nz, full;
  rd_phase_e     cur_phase, sel;
  logic [3:0]    count_nxt;
  logic [15:0]   hdr_q;
  logic [7:0]    bank_q [2];
  logic          bank_we [2];

  logic [15:0] hdr_status [DEPTH];
  logic [7:0]  hdr_runt   [DEPTH];
  logic [7:0]  hdr_coll   [DEPTH];

  assign count_nz = (frame_count != 4'd0);
  assign full     = (frame_count == 4'(DEPTH));

  rfq_ingest #(.DEPTH(DEPTH), .SLOT_BYTES(SLOT_BYTES)) u_ingest (
    .clk(clk), .rst(rst),
    .in_valid(mac_valid), .in_byte(mac_byte), .in_last(mac_last),
    .in_flags(mac_flags), .full(full),
    .wr_even(wr_even), .wr_odd(wr_odd), .wr_addr(wr_addr), .wr_byte(wr_byte),
    .commit(commit), .commit_slot(commit_slot), .commit_status(commit_status),
    .drop_done(drop_done)
  );

  rfq_reader #(.DEPTH(DEPTH), .SLOT_BYTES(SLOT_BYTES)) u_reader (
    .clk(clk), .rst(rst),
    .host_rd(host_rd), .host_next(host_next), .count_nz(count_nz),
    .head(head), .cur_phase(cur_phase), .sel(sel), .rd_fire(rd_fire),
    .ram_re(ram_re), .ram_raddr(ram_raddr), .release_head(release_head)
  );

  assign bank_we[0] = wr_even;
  assign bank_we[1] = wr_odd;

  for (genvar b = 0; b < 2; b++) begin : g_bank
    rfq_bank #(.WORDS(WORDS), .AW(AW)) u_bank (
      .clk(clk), .we(bank_we[b]), .waddr(wr_addr), .wdata(wr_byte),
      .re(ram_re), .raddr(ram_raddr), .rdata(bank_q[b])
    );
  end

  always_ff @(posedge clk) begin
    if (commit) begin
      hdr_status[commit_slot] <= commit_status;
      hdr_runt[commit_slot]   <= mac_runt;
      hdr_coll[commit_slot]   <= mac_coll;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hdr_q <= '0;
    end else if (rd_fire && count_nz) begin
      case (cur_phase)
        PH_HDR:  hdr_q <= hdr_status[head];
        PH_RUNT: hdr_q <= {8'h00, hdr_runt[head]};
        PH_COLL: hdr_q <= {8'h00, hdr_coll[head]};
        default: hdr_q <= hdr_q;
      endcase
    end
  end

  always_comb begin
    case (sel)
      PH_PAY:  host_data = {bank_q[1], bank_q[0]};
      PH_NONE: host_data = 16'h0000;
      default: host_data = hdr_q;
    endcase
  end

  assign count_nxt = frame_count + {3'b000, commit} - {3'b000, release_head};

  always_ff @(posedge clk) begin
    if (rst) begin
      frame_count <= '0;
      rx_irq      <= 1'b0;
      missed_cnt  <= '0;
    end else begin
      frame_count <= count_nxt;
      rx_irq      <= (count_nxt != 4'd0);
      if (drop_done) missed_cnt <= missed_cnt + 8'd1;
    end
  end

  // R1: the count never exceeds the queue depth
  p_count_limit_r1: assert property (@(posedge clk) disable iff (rst)
    frame_count <= 4'(DEPTH));
  // R8: interrupt follows the frame count
  p_irq_tracks_r8: assert property (@(posedge clk) disable iff (rst)
    rx_irq == (frame_count != 4'd0));
  // R2: a frame ending while full leaves the count full and bumps the miss counter
  p_full_drop_r2: assert property (@(posedge clk) disable iff (rst)
    (mac_valid && mac_last && frame_count == 4'(DEPTH) && !host_next)
    |=> (frame_count == 4'(DEPTH) && missed_cnt == $past(missed_cnt) + 8'd1));
  // R7: a release on an empty queue leaves it empty
  p_empty_next_r7: assert property (@(posedge clk) disable iff (rst)
    (host_next && frame_count == 4'd0 && !mac_valid) |=> frame_count == 4'd0);
endmodule

// File: tb/rx_frame_queue_test.sv
`timescale 1ns/1ps
module rx_frame_queue_test;
  localparam int DEPTH = 12;
  localparam int SLOT  = 64;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        mac_valid = 1'b0, mac_last = 1'b0;
  logic [7:0]  mac_byte = '0, mac_runt = '0, mac_coll = '0;
  logic [3:0]  mac_flags = '0;
  logic        host_rd = 1'b0, host_next = 1'b0;
  logic [15:0] host_data;
  logic [3:0]  frame_count;
  logic        rx_irq;
  logic [7:0]  missed_cnt;

  int checks = 0;
  int failures = 0;

  always #4 clk = ~clk;

  rx_frame_queue #(.DEPTH(DEPTH), .SLOT_BYTES(SLOT)) uut (
    .clk(clk), .rst(rst), .mac_valid(mac_valid), .mac_byte(mac_byte),
    .mac_last(mac_last), .mac_flags(mac_flags), .mac_runt(mac_runt),
    .mac_coll(mac_coll), .host_rd(host_rd), .host_next(host_next),
    .host_data(host_data), .frame_count(frame_count), .rx_irq(rx_irq),
    .missed_cnt(missed_cnt)
  );

  function automatic logic [7:0] byte_at(int seed, int i);
    return 8'((seed * 37) + (i * 11) + (i >> 3));
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic send_frame(input int len, input logic [3:0] fl,
                            input logic [7:0] rn, input logic [7:0] cl, input int seed);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      mac_valid = 1'b1;
      mac_byte  = byte_at(seed, i);
      mac_last  = (i == len - 1);
      mac_flags = fl;
      mac_runt  = rn;
      mac_coll  = cl;
    end
    @(negedge clk);
    mac_valid = 1'b0;
    mac_last  = 1'b0;
  endtask

  task automatic read_word(output logic [15:0] d);
    @(negedge clk);
    host_rd = 1'b1;
    @(negedge clk);
    host_rd = 1'b0;
    d = host_data;
  endtask

  task automatic pulse_next;
    @(negedge clk);
    host_next = 1'b1;
    @(negedge clk);
    host_next = 1'b0;
  endtask

  // nwords < 0: read whole stored payload; 0: status word only
  task automatic check_frame(input int len, input logic [3:0] fl, input logic [7:0] rn,
                             input logic [7:0] cl, input int seed, input int nwords);
    logic [15:0] d;
    int stored, words, lenf;
    logic ovf;
    stored = (len > SLOT) ? SLOT : len;
    lenf   = (len > 4095) ? 4095 : len;
    ovf    = fl[3] | (len > SLOT);
    read_word(d);
    chk("R3 status", d, {ovf, fl[2:0], 12'(lenf)});
    if (nwords == 0) return;
    read_word(d);
    chk("R4 runt", d, {8'h00, rn});
    read_word(d);
    chk("R4 coll", d, {8'h00, cl});
    words = (stored + 1) / 2;
    for (int j = 0; j < words; j++) begin
      read_word(d);
      chk("R5 low byte", d[7:0], byte_at(seed, 2 * j));
      if (2 * j + 1 < stored) chk("R5 high byte", d[15:8], byte_at(seed, 2 * j + 1));
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [15:0] d;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 reset count", frame_count, 0);
    chk("R8 reset irq", rx_irq, 0);
    chk("R2 reset missed", missed_cnt, 0);

    // R7: empty queue operations
    read_word(d);
    chk("R7 empty read", d, 0);
    pulse_next();
    chk("R7 next on empty", frame_count, 0);
    send_frame(6, 4'h0, 8'h11, 8'h22, 5);
    chk("R1 one frame", frame_count, 1);
    chk("R8 irq set", rx_irq, 1);
    check_frame(6, 4'h0, 8'h11, 8'h22, 5, -1);
    // R11: data held while idle
    repeat (3) @(negedge clk);
    chk("R11 held", host_data[7:0], byte_at(5, 4));
    pulse_next();
    chk("R6 count after next", frame_count, 0);
    chk("R8 irq clear", rx_irq, 0);

    // Length sweep, wraps the slot ring many times (R10)
    for (int len = 1; len <= SLOT; len++) begin
      send_frame(len, 4'(len), 8'(len), 8'(255 - len), len);
      chk("R1 sweep count", frame_count, 1);
      check_frame(len, 4'(len), 8'(len), 8'(255 - len), len, -1);
      pulse_next();
      chk("R8 sweep irq", rx_irq, 0);
    end

    // Fill, overflow, drain in order
    for (int k = 0; k < DEPTH; k++) begin
      send_frame(20 + k, 4'(k), 8'(k), 8'(k + 50), 100 + k);
      chk("R1 fill count", frame_count, k + 1);
    end
    send_frame(9, 4'h0, 8'h00, 8'h00, 77);
    chk("R2 dropped count", frame_count, DEPTH);
    chk("R2 missed", missed_cnt, 1);
    for (int k = 0; k < DEPTH; k++) begin
      check_frame(20 + k, 4'(k), 8'(k), 8'(k + 50), 100 + k, (k % 2 == 0) ? -1 : 0);
      pulse_next();
      chk("R6 drain count", frame_count, DEPTH - 1 - k);
    end
    chk("R8 drained irq", rx_irq, 0);

    // Truncation and saturation
    send_frame(70, 4'h2, 8'h05, 8'h06, 9);
    check_frame(70, 4'h2, 8'h05, 8'h06, 9, -1);
    pulse_next();
    send_frame(4100, 4'h1, 8'h07, 8'h08, 3);
    check_frame(4100, 4'h1, 8'h07, 8'h08, 3, 0);
    pulse_next();
    chk("R9 final count", frame_count, 0);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule